// File: doc/BRIEF.md
# Indirect Interrupt Redirection Unit

The block routes a set of external interrupt pins to interrupt messages. Every pin has a 64-bit routing entry that holds a vector, a delivery mode, a destination mode, an active-low flag, a level/edge flag, a mask and a destination. Software reaches all registers through an index register and a single data window. It writes the register number to the select offset and then reads or writes the data window.

When an unmasked pin becomes active under its polarity and trigger setting, the unit presents a message that carries the vector, destination and the two mode fields of the entry. The message is held on a valid/ready output. For level-mode entries, a read-only pending bit blocks further messages until an end-of-interrupt with the same vector arrives. When several pins ask at once, the lowest-numbered pin is sent first. Edge requests that arrive while the output is stalled are held until they can be sent.

Top module: `irq_route_unit`

## Requirements
- R1: A write at byte offset 0x00 loads the 8-bit index register, and a read there returns it in bits 7:0. Reads and writes at offset 0x10 reach the register that the index selects. Reads at any other offset return zero.
- R2: Index 0 reads the unit ID in bits 31:24 and zero elsewhere. Index 1 reads the version in bits 7:0 and the number of routing entries in bits 23:16. Writes to both indices are ignored.
- R3: Entry n is split across two indices. Its low word sits at index 0x10+2n: vector 7:0, delivery mode 10:8, destination mode 11, active-low 13, remote-pending 14 (read-only), level trigger 15, mask 16. Its high word sits at index 0x11+2n, with the destination in bits 31:24. All other bits read zero.
- R4: After reset the index is 0, no message is valid, and every entry reads back with only its mask bit set.
- R5: A pin whose entry has the mask bit set produces no message.
- R6: In edge mode, each inactive-to-active transition produces exactly one message. A pin held active produces no further messages.
- R7: With the active-low bit set, the pin is inverted before edge or level detection.
- R8: In level mode, an active pin produces one message and sets the remote-pending bit. No further message follows. An EOI whose vector differs from the entry's vector has no effect.
- R9: An EOI with a matching vector clears remote-pending. If the pin is still active at that point, one new message follows. If it is inactive, none does.
- R10: When several pins request at once, messages leave in ascending pin order.
- R11: While valid is high and ready is low, the message stays unchanged. Edge requests that arrive in the meantime are delivered later.
- R12: Writes to indices above the last entry are ignored, and reads from those indices return zero.
- R13: A message carries its entry's vector, destination, delivery mode and destination mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset (0x00 select, 0x10 window) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_pin | input | N_PINS | Interrupt pins, synchronous to clk |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_valid | output | 1 | Message present |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_dlv_mode | output | 3 | Message delivery mode |
| msg_dest_mode | output | 1 | Message destination mode |

## Verification
Single pins are driven with rising pulses, long held-active levels, and inverted (active-low) transitions. These patterns separate a single message per edge from a repeating request, and show whether the polarity inversion is applied before detection. Level-mode pins are acknowledged with a wrong vector and then with the right vector, both while the pin is still high and after it has fallen. This separates re-delivery from a plain clear of the pending bit. Three pins rising together while the consumer stalls show both the stability of the held message and the ascending drain order that follows.

// File: rtl/irq_route_pkg.sv
// Shared types and constants for the indirect interrupt redirection unit.
// Assumes at most 120 entries so every entry index fits in the 8-bit index.
package irq_route_pkg;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig_level;
        logic       pol_low;
        logic       dest_mode;
        logic [2:0] dlv_mode;
        logic [7:0] vector;
    } route_entry_t;

    localparam logic [4:0] OFS_SELECT = 5'h00;
    localparam logic [4:0] OFS_WINDOW = 5'h10;
    localparam logic [7:0] IDX_ID     = 8'h00;
    localparam logic [7:0] IDX_VER    = 8'h01;
    localparam logic [7:0] IDX_TABLE  = 8'h10;

    // Routing entry value after reset: masked, all else zero.
    function automatic route_entry_t entry_reset();
        route_entry_t e;
        e      = '0;
        e.mask = 1'b1;
        return e;
    endfunction

endpackage

// File: rtl/irq_route_table.sv
// Index register, routing table storage and the read mux of the data window.
// Assumes reg_addr is a byte offset. Reads are combinational, writes take
// effect at the clock edge. remote_pend is owned by the pin logic and only
// shown here as a read-only bit.
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int          N_PINS  = 8,
    parameter logic [7:0]  UNIT_ID = 8'hA5,
    parameter logic [7:0]  VERSION = 8'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [4:0]         addr,
    input  logic [31:0]        wdata,
    input  logic [N_PINS-1:0]  remote_pend,
    output logic [31:0]        rdata,
    output route_entry_t       entries [N_PINS]
);

    localparam int TBL_SPAN = 2 * N_PINS;

    logic [7:0] idx_q;
    logic [7:0] rel_idx;
    logic [6:0] slot;
    logic       hi_word;
    logic       in_table;
    logic       win_wr;
    logic [31:0] win_rd;
    logic       unused_wbits;

    assign rel_idx  = idx_q - IDX_TABLE;
    assign slot     = rel_idx[7:1];
    assign hi_word  = rel_idx[0];
    assign in_table = (idx_q >= IDX_TABLE) && ({1'b0, rel_idx} < 9'(TBL_SPAN));
    assign win_wr   = wr_en && (addr == OFS_WINDOW);
    assign unused_wbits = ^{wdata[23:17], wdata[14], wdata[12]};

    // Index register: loaded by writes to the select offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= IDX_ID;
        else if (wr_en && addr == OFS_SELECT)
            idx_q <= wdata[7:0];
    end

    // One storage slot per entry, written through the window.
    for (genvar gi = 0; gi < N_PINS; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[gi] <= entry_reset();
            end else if (win_wr && in_table && slot == 7'(gi)) begin
                if (hi_word) begin
                    entries[gi].dest <= wdata[31:24];
                end else begin
                    entries[gi].vector     <= wdata[7:0];
                    entries[gi].dlv_mode   <= wdata[10:8];
                    entries[gi].dest_mode  <= wdata[11];
                    entries[gi].pol_low    <= wdata[13];
                    entries[gi].trig_level <= wdata[15];
                    entries[gi].mask       <= wdata[16];
                end
            end
        end
    end

    // Data window: value of the register selected by the index.
    always_comb begin
        win_rd = '0;
        if (idx_q == IDX_ID) begin
            win_rd = {UNIT_ID, 24'h0};
        end else if (idx_q == IDX_VER) begin
            win_rd = {8'h0, 8'(N_PINS), 8'h0, VERSION};
        end else if (in_table) begin
            for (int i = 0; i < N_PINS; i++) begin
                if (slot == 7'(i)) begin
                    if (hi_word)
                        win_rd = {entries[i].dest, 24'h0};
                    else
                        win_rd = {15'h0, entries[i].mask, entries[i].trig_level,
                                  remote_pend[i], entries[i].pol_low, 1'b0,
                                  entries[i].dest_mode, entries[i].dlv_mode,
                                  entries[i].vector};
                end
            end
        end
    end

    // Port read mux: index, window, or zero.
    always_comb begin
        if (addr == OFS_SELECT)
            rdata = {24'h0, idx_q};
        else if (addr == OFS_WINDOW)
            rdata = win_rd;
        else
            rdata = '0;
    end

endmodule

// File: rtl/irq_route_src.sv
// Request logic for one interrupt pin: polarity, edge capture, level gating
// and the remote-pending bit. Assumes the pin is already synchronous to clk.
// The grant input comes from the arbiter in the cycle the message is loaded.
module irq_route_src
    import irq_route_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  route_entry_t  ent,
    input  logic          eoi_valid,
    input  logic [7:0]    eoi_vector,
    input  logic          grant,
    output logic          req,
    output logic          remote
);

    logic active;
    logic prev_q;
    logic rise;
    logic pend_q;
    logic eoi_hit;

    assign active  = pin ^ ent.pol_low;
    assign rise    = active && !prev_q;
    assign eoi_hit = eoi_valid && (eoi_vector == ent.vector);

    // Requests: level uses the live input, edge uses the captured transition.
    always_comb begin
        if (ent.trig_level)
            req = active && !ent.mask && !remote;
        else
            req = (pend_q || rise) && !ent.mask;
    end

    // Previous active state, for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= active;
    end

    // Edge capture: set by an unmasked transition, cleared when sent.
    always_ff @(posedge clk) begin
        if (!rst_n || ent.trig_level)
            pend_q <= 1'b0;
        else
            pend_q <= (pend_q || (rise && !ent.mask)) && !grant;
    end

    // Remote-pending: set on a level delivery, cleared by a matching EOI.
    always_ff @(posedge clk) begin
        if (!rst_n || !ent.trig_level)
            remote <= 1'b0;
        else if (grant)
            remote <= 1'b1;
        else if (eoi_hit)
            remote <= 1'b0;
    end

endmodule

// File: rtl/irq_route_arb.sv
// Picks the lowest-numbered requesting pin and holds its message on a
// valid/ready output register. A new message loads only when the register
// is empty or being emptied in the same cycle.
module irq_route_arb
    import irq_route_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PINS-1:0]  req,
    input  route_entry_t       entries [N_PINS],
    input  logic               msg_ready,
    output logic [N_PINS-1:0]  grant,
    output logic               msg_valid,
    output logic [7:0]         msg_vector,
    output logic [7:0]         msg_dest,
    output logic [2:0]         msg_dlv_mode,
    output logic               msg_dest_mode
);

    localparam int IDX_W = (N_PINS > 1) ? $clog2(N_PINS) : 1;

    logic [IDX_W-1:0] win_idx;
    logic             found;
    logic             load;

    // Fixed priority: scan downward so the lowest index wins.
    always_comb begin
        win_idx = '0;
        found   = 1'b0;
        for (int i = N_PINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
    end

    assign load = found && (!msg_valid || msg_ready);

    // One-hot grant back to the pin that is being loaded.
    always_comb begin
        for (int i = 0; i < N_PINS; i++)
            grant[i] = load && (win_idx == IDX_W'(i));
    end

    // Output message register with valid/ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid     <= 1'b0;
            msg_vector    <= '0;
            msg_dest      <= '0;
            msg_dlv_mode  <= '0;
            msg_dest_mode <= 1'b0;
        end else if (load) begin
            msg_valid     <= 1'b1;
            msg_vector    <= entries[win_idx].vector;
            msg_dest      <= entries[win_idx].dest;
            msg_dlv_mode  <= entries[win_idx].dlv_mode;
            msg_dest_mode <= entries[win_idx].dest_mode;
        end else if (msg_ready) begin
            msg_valid     <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_route_unit.sv
// Top of the indirect interrupt redirection unit. It ties the register
// window, one request slice per pin and the output arbiter together.
// Assumes N_PINS <= 120 and pins synchronous to clk.
module irq_route_unit
    import irq_route_pkg::*;
#(
    parameter int          N_PINS  = 8,
    parameter logic [7:0]  UNIT_ID = 8'hA5,
    parameter logic [7:0]  VERSION = 8'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [4:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [N_PINS-1:0]  irq_pin,
    input  logic               eoi_valid,
    input  logic [7:0]         eoi_vector,
    input  logic               msg_ready,
    output logic               msg_valid,
    output logic [7:0]         msg_vector,
    output logic [7:0]         msg_dest,
    output logic [2:0]         msg_dlv_mode,
    output logic               msg_dest_mode
);

    route_entry_t       entries [N_PINS];
    logic [N_PINS-1:0]  remote;
    logic [N_PINS-1:0]  req;
    logic [N_PINS-1:0]  grant;

    irq_route_table #(
        .N_PINS  (N_PINS),
        .UNIT_ID (UNIT_ID),
        .VERSION (VERSION)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .remote_pend (remote),
        .rdata       (reg_rdata),
        .entries     (entries)
    );

    for (genvar gp = 0; gp < N_PINS; gp++) begin : g_src
        irq_route_src u_src (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (irq_pin[gp]),
            .ent        (entries[gp]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .grant      (grant[gp]),
            .req        (req[gp]),
            .remote     (remote[gp])
        );
    end

    irq_route_arb #(
        .N_PINS (N_PINS)
    ) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .entries       (entries),
        .msg_ready     (msg_ready),
        .grant         (grant),
        .msg_valid     (msg_valid),
        .msg_vector    (msg_vector),
        .msg_dest      (msg_dest),
        .msg_dlv_mode  (msg_dlv_mode),
        .msg_dest_mode (msg_dest_mode)
    );

endmodule

// File: rtl/irq_route_sva.sv
// Protocol checker for irq_route_unit, attached by bind below.
// Observes the output handshake, the register port and the grant/request
// vectors between the pin slices and the arbiter.
module irq_route_sva #(
    parameter int N_PINS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [7:0]         msg_vector,
    input logic [7:0]         msg_dest,
    input logic [4:0]         reg_addr,
    input logic [31:0]        reg_rdata,
    input logic [N_PINS-1:0]  req,
    input logic [N_PINS-1:0]  grant
);

    // R4: reset leaves no message pending
    assert_reset_idle_R4: assert property (@(posedge clk)
        !rst_n |=> !msg_valid);

    // R11: a stalled message does not change
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)));

    // R11: nothing is granted while the output is blocked
    assert_grant_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |-> (grant == '0));

    // R10: at most one pin granted
    assert_grant_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10: the grant goes to a requester with no lower-numbered requester
    assert_grant_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (((grant & req) == grant) && (((grant - 1'b1) & req) == '0)));

    // R1: unmapped offsets read zero
    assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != 5'h00 && reg_addr != 5'h10) |-> (reg_rdata == 32'h0));

endmodule

bind irq_route_unit irq_route_sva #(.N_PINS(N_PINS)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_vector (msg_vector),
    .msg_dest   (msg_dest),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .req        (req),
    .grant      (grant)
);

// File: tb/irq_route_unit_tb.sv
// Directed bench for irq_route_unit: one task per scenario, each checking
// its own results. Inputs change on the falling edge; outputs are sampled there.
module irq_route_unit_tb;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] irq_pin = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_ready = 1'b1;
    logic        msg_valid;
    logic [7:0]  msg_vector;
    logic [7:0]  msg_dest;
    logic [2:0]  msg_dlv_mode;
    logic        msg_dest_mode;

    int n_checks = 0;
    int n_fail   = 0;
    int msg_cnt  = 0;
    logic [7:0] msg_log [16];

    always #5 clk = ~clk;

    irq_route_unit #(.N_PINS(N), .UNIT_ID(8'hA5), .VERSION(8'h11)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_pin(irq_pin),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_dlv_mode(msg_dlv_mode), .msg_dest_mode(msg_dest_mode)
    );

    // Records every accepted message in order.
    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (msg_cnt < 16) msg_log[msg_cnt] <= msg_vector;
            msg_cnt <= msg_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
        reg_wr(5'h00, {24'h0, idx});
        reg_wr(5'h10, d);
    endtask

    task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
        reg_wr(5'h00, {24'h0, idx});
        reg_addr = 5'h10;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_addr = 5'h00; #1;
        chk("R4 index", reg_rdata, 32'h0);
        chk("R4 msg_valid", {31'h0, msg_valid}, 32'h0);
        win_rd(8'h00, v); chk("R2 id", v, 32'hA500_0000);
        win_rd(8'h01, v); chk("R2 version", v, 32'h0008_0011);
        win_rd(8'h10, v); chk("R4 entry0 low", v, 32'h0001_0000);
        win_rd(8'h1F, v); chk("R4 entry7 high", v, 32'h0);
        reg_addr = 5'h00; #1;
        chk("R1 index readback", reg_rdata, 32'h1F);
        reg_addr = 5'h04; #1;
        chk("R1 other offset", reg_rdata, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        win_wr(8'h16, 32'hFFFF_FFFF);
        win_wr(8'h17, 32'hFFFF_FFFF);
        win_rd(8'h16, v); chk("R3 low fields", v, 32'h0001_AFFF);
        win_rd(8'h17, v); chk("R3 high dest", v, 32'hFF00_0000);
        win_wr(8'h16, 32'h0001_0000);
        win_wr(8'h17, 32'h0);
    endtask

    task automatic t_out_of_range();
        logic [31:0] v;
        win_wr(8'h20, 32'hDEAD_BEEF);
        win_rd(8'h20, v); chk("R12 oor read", v, 32'h0);
        win_rd(8'h05, v); chk("R12 gap read", v, 32'h0);
        win_rd(8'h1E, v); chk("R12 last entry intact", v, 32'h0001_0000);
        win_wr(8'h00, 32'h1234_5678);
        win_rd(8'h00, v); chk("R2 id write ignored", v, 32'hA500_0000);
    endtask

    task automatic t_masked();
        int base;
        logic [31:0] v;
        win_wr(8'h14, 32'h0001_0032);
        base = msg_cnt;
        irq_pin[2] = 1'b1; idle(4);
        irq_pin[2] = 1'b0; idle(4);
        chk("R5 masked no message", msg_cnt - base, 0);
        win_rd(8'h14, v); chk("R5 entry kept", v, 32'h0001_0032);
    endtask

    task automatic t_edge();
        int base;
        win_wr(8'h12, 32'h0000_0941);
        win_wr(8'h13, 32'h0700_0000);
        base = msg_cnt;
        irq_pin[1] = 1'b1;
        @(negedge clk);
        chk("R6 edge valid", {31'h0, msg_valid}, 32'h1);
        chk("R13 vector", {24'h0, msg_vector}, 32'h41);
        chk("R13 dest", {24'h0, msg_dest}, 32'h07);
        chk("R13 modes", {28'h0, msg_dlv_mode, msg_dest_mode}, 32'h3);
        idle(6);
        chk("R6 held active one message", msg_cnt - base, 1);
        irq_pin[1] = 1'b0; idle(2);
        irq_pin[1] = 1'b1; idle(3);
        irq_pin[1] = 1'b0; idle(2);
        chk("R6 second edge", msg_cnt - base, 2);
    endtask

    task automatic t_polarity();
        int base;
        irq_pin[4] = 1'b1; idle(2);
        win_wr(8'h18, 32'h0000_2044);
        idle(2);
        base = msg_cnt;
        chk("R7 high level inactive", msg_cnt - base, 0);
        irq_pin[4] = 1'b0; idle(3);
        chk("R7 falling pin sends", msg_cnt - base, 1);
        if (msg_cnt > 0) chk("R7 vector", {24'h0, msg_log[msg_cnt-1]}, 32'h44);
        irq_pin[4] = 1'b1; idle(3);
        chk("R7 rising pin silent", msg_cnt - base, 1);
    endtask

    task automatic t_level();
        int base;
        logic [31:0] v;
        win_wr(8'h1A, 32'h0000_8055);
        base = msg_cnt;
        irq_pin[5] = 1'b1; idle(6);
        chk("R8 one level message", msg_cnt - base, 1);
        win_rd(8'h1A, v); chk("R8 remote set", v, 32'h0000_C055);
        eoi_valid = 1'b1; eoi_vector = 8'h56; @(negedge clk); eoi_valid = 1'b0;
        idle(4);
        chk("R8 wrong eoi ignored", msg_cnt - base, 1);
        eoi_valid = 1'b1; eoi_vector = 8'h55; @(negedge clk); eoi_valid = 1'b0;
        idle(4);
        chk("R9 still active resend", msg_cnt - base, 2);
        irq_pin[5] = 1'b0; idle(1);
        eoi_valid = 1'b1; eoi_vector = 8'h55; @(negedge clk); eoi_valid = 1'b0;
        idle(4);
        chk("R9 inactive no resend", msg_cnt - base, 2);
        win_rd(8'h1A, v); chk("R9 remote cleared", v, 32'h0000_8055);
    endtask

    task automatic t_priority();
        int base;
        win_wr(8'h1C, 32'h0000_0066);
        win_wr(8'h1E, 32'h0000_0077);
        idle(2);
        base = msg_cnt;
        msg_ready = 1'b0;
        irq_pin[7] = 1'b1; irq_pin[6] = 1'b1; irq_pin[1] = 1'b1;
        @(negedge clk);
        chk("R10 first is lowest", {24'h0, msg_vector}, 32'h41);
        idle(3);
        chk("R11 stall valid", {31'h0, msg_valid}, 32'h1);
        chk("R11 stall vector", {24'h0, msg_vector}, 32'h41);
        msg_ready = 1'b1;
        idle(6);
        chk("R11 all delivered", msg_cnt - base, 3);
        chk("R10 order 0", {24'h0, msg_log[base]}, 32'h41);
        chk("R10 order 1", {24'h0, msg_log[base+1]}, 32'h66);
        chk("R10 order 2", {24'h0, msg_log[base+2]}, 32'h77);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_out_of_range();
        t_masked();
        t_edge();
        t_polarity();
        t_level();
        t_priority();
        finish_run();
    end

endmodule